// File: doc/BRIEF.md
# Serial Line Rate Buffer

This block joins a fast internal serial bit stream to a slow 1200 bit/s telephone-line modem path, in both directions. On the send side, six-bit characters arrive one bit at a time at the internal rate (about one bit every 3.43 µs). They are packed and parked in a short chain of three character registers. A line framer drains that chain one bit per line period. It wraps each character in a start bit, an odd parity bit and a stop bit, and opens and closes each message with dedicated control characters.

On the receive side the same steps run in reverse. The line is sampled once per line bit and parity is checked. Characters that fall inside a message are stored in a second three-deep chain. They are then replayed to the internal side at the fast rate, one bit per strobe. A carriage-return character raises a one-clock flag in each direction. Both bit rates come from parameterised clock dividers, so a bench can shrink the line period without touching the logic.

Top module: `serial_rate_buffer`

## Requirements
- R1: `line_tx` rests at mark (1) after reset, between frames and after a message has been closed.
- R2: Every line bit lasts exactly LINE_DIV clocks. A frame is a start bit 0, then the six data bits with bit 0 first, then a parity bit that makes the count of ones over data and parity odd, then a stop bit 1. Data bits 0..2 are the first three-bit group (X0..X2) and bits 3..5 are the second (Y0..Y2), so capital A is 6'b100001.
- R3: When the send buffer holds a character while no message is open, the framer first sends the message-open code 6'b111110, then the buffered characters in arrival order. When the buffer is empty at a frame boundary, it sends the message-close code 6'b111101 and returns to idle.
- R4: `tx_bit_in` is taken on clocks where `tx_bit_valid` and `tx_ready` are both high, bit 0 first, six bits per character. Up to three characters wait in the buffer. `tx_ready` is low while three are waiting, and bits offered while it is low are ignored.
- R5: `tx_cr_seen` pulses for one clock when a data character with the carriage-return code 6'b001101 begins transmission.
- R6: A received data frame is delivered only if it arrives after a message-open frame and before the next message-close frame. Frames are delivered in order, and the two control codes are never delivered.
- R7: A delivered character appears on `rx_bit_out` bit 0 first, one bit per one-clock `rx_bit_valid` pulse, with the pulses of a character exactly FAST_DIV clocks apart.
- R8: `rx_parity_err` goes high when any received frame has an even count of ones over its data and parity bits, and stays high until reset.
- R9: `rx_cr_seen` pulses for one clock when a received frame carries the carriage-return code 6'b001101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit_in | input | 1 | Fast-side serial data to send |
| tx_bit_valid | input | 1 | Strobe qualifying `tx_bit_in` |
| tx_ready | output | 1 | High while the send buffer has room |
| line_tx | output | 1 | Serial data toward the modem |
| line_rx | input | 1 | Serial data from the modem, synchronous to `clk` |
| rx_bit_out | output | 1 | Fast-side serial data received |
| rx_bit_valid | output | 1 | One-clock strobe qualifying `rx_bit_out` |
| tx_cr_seen | output | 1 | Carriage return started on the line |
| rx_cr_seen | output | 1 | Carriage return received from the line |
| rx_parity_err | output | 1 | Sticky receive parity fault |

## Verification
A packing slip or a lost slot in the send chain shows up as a wrong character on the line within one frame, about nine line periods. The bench decodes every frame at mid-bit and compares it with the character queue it filled. The same characters loop back through the receiver. A fault in the receive state, such as a missed start, a stale message-open state or a shifted unpacker, appears as a wrong or unexpected character on the fast output about six fast strobes after the frame's parity bit. A parity fault is checked with frames injected directly on the line, and a missing flag shows within two line periods.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int CHAR_W  = 6;
    localparam int FRAME_W = CHAR_W + 3;
    localparam int LEFT_W  = $clog2(FRAME_W);

    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t CODE_OPEN  = 6'b111110;
    localparam char_t CODE_CLOSE = 6'b111101;
    localparam char_t CODE_CR    = 6'b001101;

    // parity bit that makes the ones count over data + parity odd
    function automatic logic odd_bit(input char_t c);
        return ~^c;
    endfunction

    // line order, index 0 goes first: start, data LSB first, parity, stop
    function automatic logic [FRAME_W-1:0] build_frame(input char_t c);
        return {1'b1, odd_bit(c), c, 1'b0};
    endfunction
endpackage

// File: rtl/rb_tick.sv
module rb_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt   = '0;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.pulse;

    generate
        if (DIV > 1) begin : g_chk
            AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.pulse |=> !st_q.pulse); // R2
        end
    endgenerate
endmodule

// File: rtl/rb_char_fifo.sv
module rb_char_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic pop_ok, push_ok;
    logic [CNT_W-1:0] wr_at;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign head  = st_q.slot[0];

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        wr_at   = st_q.cnt - CNT_W'(pop_ok);
        if (pop_ok) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[DEPTH-1] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && (wr_at == CNT_W'(i))) st_d.slot[i] = push_data;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
endmodule

// File: rtl/rb_tx_path.sv
module rb_tx_path
    import rb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic bit_in,
    input  logic bit_valid,
    output logic ready,
    output logic line_out,
    output logic cr_seen
);
    localparam int PK_W = $clog2(CHAR_W);

    typedef struct packed {
        char_t                pk_sh;
        logic [PK_W-1:0]      pk_cnt;
        logic [FRAME_W-2:0]   sh;
        logic [LEFT_W-1:0]    left;
        logic                 open;
        logic                 line;
        logic                 cr;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic push, pop, empty, full;
    char_t push_data, head;
    logic [FRAME_W-1:0] frame;
    logic load;

    rb_char_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .head(head), .empty(empty), .full(full)
    );

    assign ready = !full;

    always_comb begin
        st_d   = st_q;
        st_d.cr = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        load   = 1'b0;
        frame  = '1;
        // fast side: pack six bits, bit 0 first
        if (bit_valid && !full) begin
            st_d.pk_sh = {bit_in, st_q.pk_sh[CHAR_W-1:1]};
            if (st_q.pk_cnt == PK_W'(CHAR_W - 1)) begin
                st_d.pk_cnt = '0;
                push        = 1'b1;
            end else begin
                st_d.pk_cnt = st_q.pk_cnt + 1'b1;
            end
        end
        push_data = st_d.pk_sh;
        // line side: one bit per tick
        if (line_tick) begin
            if (st_q.left != '0) begin
                st_d.line = st_q.sh[0];
                st_d.sh   = st_q.sh >> 1;
                st_d.left = st_q.left - 1'b1;
            end else begin
                if (!st_q.open) begin
                    if (!empty) begin
                        frame     = build_frame(CODE_OPEN);
                        st_d.open = 1'b1;
                        load      = 1'b1;
                    end
                end else if (!empty) begin
                    frame   = build_frame(head);
                    pop     = 1'b1;
                    load    = 1'b1;
                    st_d.cr = (head == CODE_CR);
                end else begin
                    frame     = build_frame(CODE_CLOSE);
                    st_d.open = 1'b0;
                    load      = 1'b1;
                end
                if (load) begin
                    st_d.line = frame[0];
                    st_d.sh   = frame[FRAME_W-1:1];
                    st_d.left = LEFT_W'(FRAME_W - 1);
                end else begin
                    st_d.line = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_out = st_q.line;
    assign cr_seen  = st_q.cr;

    AST_MARK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left == '0) |-> st_q.line); // R1
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(st_q.line)); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !ready) |=> $stable(st_q.pk_cnt)); // R4
    AST_CR_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cr |-> $past(line_tick)); // R5
endmodule

// File: rtl/rb_rx_path.sv
module rb_rx_path
    import rb_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic fast_tick,
    input  logic line_in,
    output logic bit_out,
    output logic bit_valid,
    output logic parity_err,
    output logic cr_seen
);
    localparam int SH_W = FRAME_W - 2;
    localparam int UP_W = $clog2(CHAR_W);

    typedef struct packed {
        logic               busy;
        logic [2:0]         cnt;
        logic [SH_W-1:0]    sh;
        logic               open;
        logic               perr;
        logic               cr;
        char_t              up_sh;
        logic [UP_W-1:0]    up_left;
        logic               out;
        logic               vld;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic push, pop, empty, full;
    char_t head, data;
    logic [SH_W-1:0] got;

    rb_char_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(data),
        .pop(pop), .head(head), .empty(empty), .full(full)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cr  = 1'b0;
        st_d.vld = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        got      = {line_in, st_q.sh[SH_W-1:1]};
        data     = got[CHAR_W-1:0];
        // line side: one sample per tick, data then parity
        if (line_tick) begin
            if (!st_q.busy) begin
                if (!line_in) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                end
            end else begin
                st_d.sh = got;
                if (st_q.cnt == 3'(SH_W - 1)) begin
                    st_d.busy = 1'b0;
                    if (!(^got)) st_d.perr = 1'b1;
                    if (data == CODE_CR) st_d.cr = 1'b1;
                    if (data == CODE_OPEN)       st_d.open = 1'b1;
                    else if (data == CODE_CLOSE) st_d.open = 1'b0;
                    else if (st_q.open && !full) push = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
        // fast side: unpack bit 0 first
        if (fast_tick) begin
            if (st_q.up_left != '0) begin
                st_d.out     = st_q.up_sh[0];
                st_d.up_sh   = st_q.up_sh >> 1;
                st_d.up_left = st_q.up_left - 1'b1;
                st_d.vld     = 1'b1;
            end else if (!empty) begin
                pop          = 1'b1;
                st_d.out     = head[0];
                st_d.up_sh   = head >> 1;
                st_d.up_left = UP_W'(CHAR_W - 1);
                st_d.vld     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_out    = st_q.out;
    assign bit_valid  = st_q.vld;
    assign parity_err = st_q.perr;
    assign cr_seen    = st_q.cr;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.perr |=> st_q.perr); // R8
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(fast_tick)); // R7
    AST_RX_CR_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cr |-> $past(line_tick)); // R9
    AST_STORE_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.open); // R6
endmodule

// File: rtl/serial_rate_buffer.sv
module serial_rate_buffer #(
    parameter int LINE_DIV = 41667,
    parameter int FAST_DIV = 172,
    parameter int DEPTH    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_in,
    input  logic tx_bit_valid,
    output logic tx_ready,
    output logic line_tx,
    input  logic line_rx,
    output logic rx_bit_out,
    output logic rx_bit_valid,
    output logic tx_cr_seen,
    output logic rx_cr_seen,
    output logic rx_parity_err
);
    logic line_tick, fast_tick;

    rb_tick #(.DIV(LINE_DIV)) u_line_tick (
        .clk(clk), .rst_n(rst_n), .tick(line_tick)
    );

    rb_tick #(.DIV(FAST_DIV)) u_fast_tick (
        .clk(clk), .rst_n(rst_n), .tick(fast_tick)
    );

    rb_tx_path #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .bit_in(tx_bit_in), .bit_valid(tx_bit_valid), .ready(tx_ready),
        .line_out(line_tx), .cr_seen(tx_cr_seen)
    );

    rb_rx_path #(.DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .fast_tick(fast_tick),
        .line_in(line_rx), .bit_out(rx_bit_out), .bit_valid(rx_bit_valid),
        .parity_err(rx_parity_err), .cr_seen(rx_cr_seen)
    );
endmodule

// File: tb/test_serial_rate_buffer.sv
module test_serial_rate_buffer;
    import rb_pkg::*;

    localparam int LD = 40;
    localparam int FD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit_in = 1'b0, tx_bit_valid = 1'b0;
    logic loop = 1'b1, inj = 1'b1;
    logic tx_ready, line_tx, line_rx, rx_bit_out, rx_bit_valid;
    logic tx_cr_seen, rx_cr_seen, rx_parity_err;

    always #10 clk = ~clk;
    assign line_rx = loop ? line_tx : inj;

    serial_rate_buffer #(.LINE_DIV(LD), .FAST_DIV(FD), .DEPTH(3)) i_serial_rate_buffer (
        .clk(clk), .rst_n(rst_n), .tx_bit_in(tx_bit_in), .tx_bit_valid(tx_bit_valid),
        .tx_ready(tx_ready), .line_tx(line_tx), .line_rx(line_rx),
        .rx_bit_out(rx_bit_out), .rx_bit_valid(rx_bit_valid),
        .tx_cr_seen(tx_cr_seen), .rx_cr_seen(rx_cr_seen), .rx_parity_err(rx_parity_err)
    );

    int checks = 0, errors = 0, cyc = 0;
    int tx_cr_cnt = 0, rx_cr_cnt = 0;
    char_t rx_q[$];
    char_t line_q[$];

    always @(posedge clk) cyc++;
    always @(negedge clk) begin
        if (tx_cr_seen) tx_cr_cnt++;
        if (rx_cr_seen) rx_cr_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: queue expectations, then feed six bits
    task automatic send_char(input char_t c);
        rx_q.push_back(c);
        line_q.push_back(c);
        for (int b = 0; b < CHAR_W; b++) begin
            while (!tx_ready) @(negedge clk);
            tx_bit_in = c[b];
            tx_bit_valid = 1'b1;
            @(negedge clk);
            tx_bit_valid = 1'b0;
        end
    endtask

    task automatic inject(input char_t c, input bit bad);
        logic [FRAME_W-1:0] f;
        f = {1'b1, (~^c) ^ bad, c, 1'b0};
        for (int b = 0; b < FRAME_W; b++) begin
            inj = f[b];
            repeat (LD) @(negedge clk);
        end
    endtask

    task automatic drain();
        while (line_q.size() != 0 || rx_q.size() != 0) @(negedge clk);
        repeat (2 * LD) @(negedge clk);
    endtask

    // monitor: fast receive output
    initial begin : mon_rx
        char_t acc, e;
        int n, last;
        n = 0; last = 0; acc = '0;
        forever begin
            @(negedge clk);
            if (rx_bit_valid) begin
                if (n > 0) chk(cyc - last == FD, "R7", "strobe spacing", cyc - last, FD);
                last = cyc;
                acc[n] = rx_bit_out;
                n++;
                if (n == CHAR_W) begin
                    n = 0;
                    if (rx_q.size() == 0) chk(1'b0, "R6", "unexpected rx char", int'(acc), -1);
                    else begin
                        e = rx_q.pop_front();
                        chk(acc == e, "R6", "rx char", int'(acc), int'(e));
                    end
                end
            end
        end
    end

    // monitor: line frames, sampled mid-bit
    initial begin : mon_line
        char_t fr, e;
        logic par, stp;
        forever begin
            @(negedge clk);
            if (rst_n && line_tx == 1'b0) begin
                repeat (LD / 2) @(negedge clk);
                for (int b = 0; b < CHAR_W; b++) begin
                    repeat (LD) @(negedge clk);
                    fr[b] = line_tx;
                end
                repeat (LD) @(negedge clk); par = line_tx;
                repeat (LD) @(negedge clk); stp = line_tx;
                chk(par == ~^fr, "R2", "odd parity bit", int'(par), int'(~^fr));
                chk(stp == 1'b1, "R2", "stop bit", int'(stp), 1);
                if (line_q.size() == 0) chk(1'b0, "R3", "unexpected line frame", int'(fr), -1);
                else begin
                    e = line_q.pop_front();
                    chk(fr == e, "R3", "line frame", int'(fr), int'(e));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int c0, c1;
        repeat (3) @(negedge clk);
        chk(line_tx == 1'b1, "R1", "line idle at reset", int'(line_tx), 1);
        chk(tx_ready == 1'b1, "R4", "ready at reset", int'(tx_ready), 1);
        chk(rx_parity_err == 1'b0, "R8", "parity flag at reset", int'(rx_parity_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // message 1: capital A first, buffer filled to capacity
        line_q.push_back(CODE_OPEN);
        send_char(6'b100001);
        while (line_tx != 1'b0) @(negedge clk);
        send_char(6'b010110);
        send_char(6'b111000);
        @(negedge clk);
        chk(tx_ready == 1'b0, "R4", "ready low with three waiting", int'(tx_ready), 0);
        for (int b = 0; b < CHAR_W; b++) begin
            tx_bit_in = 1'b1;
            tx_bit_valid = 1'b1;
            @(negedge clk);
            tx_bit_valid = 1'b0;
        end
        chk(tx_ready == 1'b0, "R4", "ready still low", int'(tx_ready), 0);
        send_char(6'b000101);
        line_q.push_back(CODE_CLOSE);
        drain();
        chk(line_tx == 1'b1, "R1", "line idle after close", int'(line_tx), 1);
        chk(rx_parity_err == 1'b0, "R8", "no parity fault in loopback", int'(rx_parity_err), 0);

        // message 2 and 3: carriage returns, close on underrun
        c0 = tx_cr_cnt; c1 = rx_cr_cnt;
        line_q.push_back(CODE_OPEN);
        send_char(CODE_CR);
        line_q.push_back(CODE_CLOSE);
        drain();
        chk(line_tx == 1'b1, "R1", "line idle between messages", int'(line_tx), 1);
        line_q.push_back(CODE_OPEN);
        send_char(6'b101010);
        send_char(CODE_CR);
        send_char(6'b011001);
        line_q.push_back(CODE_CLOSE);
        drain();
        chk(tx_cr_cnt - c0 == 2, "R5", "tx carriage return pulses", tx_cr_cnt - c0, 2);
        chk(rx_cr_cnt - c1 == 2, "R9", "rx carriage return pulses", rx_cr_cnt - c1, 2);

        // direct line injection
        loop = 1'b0;
        inj = 1'b1;
        repeat (2 * LD) @(negedge clk);
        inject(6'b010101, 1'b0);            // outside a message: dropped (R6)
        inject(CODE_OPEN, 1'b0);
        rx_q.push_back(6'b000111);
        inject(6'b000111, 1'b0);
        inject(CODE_CLOSE, 1'b0);
        drain();
        chk(rx_parity_err == 1'b0, "R8", "clean frames keep flag low", int'(rx_parity_err), 0);
        inject(6'b000011, 1'b1);
        repeat (2 * LD) @(negedge clk);
        chk(rx_parity_err == 1'b1, "R8", "bad parity sets flag", int'(rx_parity_err), 1);
        inject(CODE_OPEN, 1'b0);
        rx_q.push_back(6'b110000);
        inject(6'b110000, 1'b0);
        inject(CODE_CLOSE, 1'b0);
        drain();
        chk(rx_parity_err == 1'b1, "R8", "flag sticky", int'(rx_parity_err), 1);
        chk(rx_q.size() == 0, "R6", "all stored chars delivered", rx_q.size(), 0);
        chk(line_tx == 1'b1, "R1", "line idle at end", int'(line_tx), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule